// File: doc/BRIEF.md
# Network Interrupt Status and Coalescing Unit

This block keeps the interrupt status of a network controller and decides when the CPU interrupt line rises. Event pulses from the device side set status bits. Clear requests from software remove them. A mask register selects which pending bits may interrupt. Only eight status sources exist. Request bits at any other position are dropped, so those status bits always read zero. The top bit is reserved. A request that touches it raises a one-cycle error flag and leaves the bit unchanged.

Enabled pending events fall into two kinds. Four completion-type sources may wait. These are receive done, receive descriptor, transmit done and transmit descriptor. The interrupt for them is held back by a programmable number of cycles, so that a burst of completions produces a single interrupt. Any other enabled pending source is urgent and raises the line at once. An urgent event that arrives during the wait ends the wait. Once the enabled pending set becomes empty, the line drops and any wait in progress is cancelled.

Top module: `intr_coalesce_top`

## Requirements
- R1: A set request writes its bits into the status register on the next clock edge, but only at implemented source positions. Those positions are receive-done bit 0, receive-descriptor bit 1, receive-idle bit 2, transmit-done bit 6, transmit-descriptor bit 7, receive-overrun bit 10, software bit 12 and transmit-idle bit 16.
- R2: A clear request removes its bits from the status register on the next edge. If a set and a clear hit the same bit in the same cycle, the bit ends set.
- R3: Status bits outside the implemented positions always read zero, whatever the requests.
- R4: A set or clear request with bit 31 high drives `rsv_err` high for exactly the cycle after that request, and status bit 31 stays zero.
- R5: `cpu_irq` stays low while (status AND mask) is zero. When (status AND mask) becomes zero, through clears or a mask write, `cpu_irq` drops one cycle later.
- R6: If (status AND mask) holds any bit outside {0, 1, 6, 7}, `cpu_irq` rises one cycle after that condition appears.
- R7: If (status AND mask) holds only bits from {0, 1, 6, 7}, `cpu_irq` rises D cycles later than an urgent event would. D is the delay register value. D = 0 gives no extra delay.
- R8: An urgent enabled bit that appears during a wait raises `cpu_irq` one cycle later.
- R9: A wait that is cancelled because (status AND mask) became zero does not fire. The next completion event starts a full new wait.
- R10: While `cpu_irq` is high and (status AND mask) stays nonzero, `cpu_irq` stays high. Further events do not change it.
- R11: After reset, status, mask and `cpu_irq` are zero, and the delay register holds the parameter `RESET_DELAY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 32 | Per-bit set requests from the device side |
| evt_clr | input | 32 | Per-bit clear requests from software |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 32 | New mask value |
| dly_we | input | 1 | Write strobe for the delay register |
| dly_wdata | input | 16 | New delay value in cycles |
| status | output | 32 | Current status register |
| rsv_err | output | 1 | Reserved-bit request error pulse |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Some properties hold on every cycle, and the assertions check them: unimplemented and reserved bits stay zero, set bits appear, and the error pulse follows a reserved request. They also check that the line is low one cycle after the enabled set empties, rises one cycle after an urgent bit, and holds while anything stays pending. Other behaviour depends on the delay value and on event order, so only the bench scenarios show it. This covers the exact cycle on which a coalesced interrupt fires, D = 0, an urgent event cutting a wait short, a cancelled wait restarting from the full delay, set winning over clear, and a mask write alone raising or dropping the line.

// File: rtl/intr_coalesce_pkg.sv
// Package: shared widths, fixed bit positions and timer state type.
// Assumes a 32-bit status word whose top bit is reserved.
package intr_coalesce_pkg;
    localparam int STAT_W     = 32;
    localparam int RSV_BIT    = STAT_W - 1;
    localparam int RXDONE_BIT = 0;
    localparam int RXDESC_BIT = 1;

    typedef enum logic [1:0] {
        TMR_QUIET  = 2'd0,
        TMR_COUNT  = 2'd1,
        TMR_RAISED = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/intr_status_reg.sv
// Status register: applies filtered set and clear requests (set wins)
// and flags any request that touches the reserved bit.
// Assumes IMPL_MASK never contains the reserved bit.
module intr_status_reg
    import intr_coalesce_pkg::*;
#(
    parameter logic [STAT_W-1:0] IMPL_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] status_o,
    output logic              rsv_err_o
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] set_f;
    logic [STAT_W-1:0] clr_f;

    // Drop requests aimed at positions that hold no source.
    always_comb begin
        set_f = set_i & IMPL_MASK;
        clr_f = clr_i & IMPL_MASK;
    end

    // Update status; set after clear so a colliding event survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            rsv_err_o <= 1'b0;
        end else begin
            status_q  <= (status_q & ~clr_f) | set_f;
            rsv_err_o <= set_i[RSV_BIT] | clr_i[RSV_BIT];
        end
    end

    assign status_o = status_q;

    a_r1_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (set_f != '0) |=> ((status_q & $past(set_f)) == $past(set_f)));
    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~IMPL_MASK) == '0);
    a_r4_rsv_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[RSV_BIT] || clr_i[RSV_BIT]) |=> rsv_err_o);
endmodule

// File: rtl/intr_classify.sv
// Classifier: forms the enabled pending set and splits it into urgent
// versus coalescable. Purely combinational.
module intr_classify
    import intr_coalesce_pkg::*;
#(
    parameter logic [STAT_W-1:0] COAL_MASK = '0
) (
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic              any_o,
    output logic              urgent_o
);
    logic [STAT_W-1:0] enabled;

    // Reduce the enabled pending bits to the two decisions the timer needs.
    always_comb begin
        enabled  = status_i & mask_i;
        any_o    = |enabled;
        urgent_o = |(enabled & ~COAL_MASK);
    end
endmodule

// File: rtl/intr_delay_timer.sv
// Delay timer: owns the CPU line. Urgent work raises it next cycle;
// coalescable-only work raises it after the programmed delay.
// Assumes the delay value is sampled only when a wait starts.
module intr_delay_timer
    import intr_coalesce_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic             urgent_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             irq_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_t       state_q;
    logic [DLY_W-1:0] cnt_q;

    // Walk quiet -> counting -> raised, dropping back when nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_QUIET;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                TMR_QUIET: begin
                    if (any_i) begin
                        if (urgent_i || delay_i == '0) begin
                            state_q <= TMR_RAISED;
                        end else begin
                            state_q <= TMR_COUNT;
                            cnt_q   <= delay_i;
                        end
                    end
                end
                TMR_COUNT: begin
                    if (!any_i) begin
                        state_q <= TMR_QUIET;
                    end else if (urgent_i || cnt_q <= ONE) begin
                        state_q <= TMR_RAISED;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                TMR_RAISED: begin
                    if (!any_i) state_q <= TMR_QUIET;
                end
                default: state_q <= TMR_QUIET;
            endcase
        end
    end

    assign irq_o = (state_q == TMR_RAISED);

    a_r5_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !any_i |=> !irq_o);
    a_r6_urgent_next: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_i |=> irq_o);
    a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && any_i) |=> irq_o);
    a_r7_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_COUNT && !urgent_i && cnt_q > ONE) |=> !irq_o);
endmodule

// File: rtl/intr_coalesce_top.sv
// Top: holds the mask and delay registers and wires status, classifier
// and timer together. Source bit positions are parameters; receive done
// and receive descriptor sit at bits 0 and 1.
module intr_coalesce_top
    import intr_coalesce_pkg::*;
#(
    parameter int               DLY_W       = 16,
    parameter logic [DLY_W-1:0] RESET_DELAY = '0,
    parameter int               TXDONE_BIT  = 6,
    parameter int               TXDESC_BIT  = 7,
    parameter int               RXOVR_BIT   = 10,
    parameter int               RXIDLE_BIT  = 2,
    parameter int               TXIDLE_BIT  = 16,
    parameter int               SWINT_BIT   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_set,
    input  logic [STAT_W-1:0] evt_clr,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              dly_we,
    input  logic [DLY_W-1:0]  dly_wdata,
    output logic [STAT_W-1:0] status,
    output logic              rsv_err,
    output logic              cpu_irq
);
    localparam logic [STAT_W-1:0] ONEHOT = STAT_W'(1);
    localparam logic [STAT_W-1:0] COAL_MASK =
        (ONEHOT << RXDONE_BIT) | (ONEHOT << RXDESC_BIT) |
        (ONEHOT << TXDONE_BIT) | (ONEHOT << TXDESC_BIT);
    localparam logic [STAT_W-1:0] IMPL_MASK = COAL_MASK |
        (ONEHOT << RXOVR_BIT) | (ONEHOT << RXIDLE_BIT) |
        (ONEHOT << TXIDLE_BIT) | (ONEHOT << SWINT_BIT);

    logic [STAT_W-1:0] mask_q;
    logic [DLY_W-1:0]  delay_q;
    logic              any_pend;
    logic              urgent_pend;

    // Software-written mask and delay registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            delay_q <= RESET_DELAY;
        end else begin
            if (mask_we) mask_q  <= mask_wdata;
            if (dly_we)  delay_q <= dly_wdata;
        end
    end

    intr_status_reg #(.IMPL_MASK(IMPL_MASK)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .clr_i    (evt_clr),
        .status_o (status),
        .rsv_err_o(rsv_err)
    );

    intr_classify #(.COAL_MASK(COAL_MASK)) u_class (
        .status_i(status),
        .mask_i  (mask_q),
        .any_o   (any_pend),
        .urgent_o(urgent_pend)
    );

    intr_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_i   (any_pend),
        .urgent_i(urgent_pend),
        .delay_i (delay_q),
        .irq_o   (cpu_irq)
    );

    a_r4_rsv_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        !status[RSV_BIT]);
endmodule

// File: tb/tb_intr_coalesce_top.sv
// Directed bench: one task per scenario, inputs driven at falling edges.
module tb_intr_coalesce_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_set = '0;
    logic [31:0] evt_clr = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        dly_we = 1'b0;
    logic [15:0] dly_wdata = '0;
    logic [31:0] status;
    logic        rsv_err;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] B_RXDONE = 32'h1;
    localparam logic [31:0] B_RXDESC = 32'h2;
    localparam logic [31:0] B_TXDONE = 32'h40;
    localparam logic [31:0] B_RXOVR  = 32'h400;
    localparam logic [31:0] B_SWINT  = 32'h1000;
    localparam logic [31:0] B_TXIDLE = 32'h10000;

    always #4 clk = ~clk;

    intr_coalesce_top dut (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .dly_we(dly_we),
        .dly_wdata(dly_wdata), .status(status), .rsv_err(rsv_err),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(cpu_irq === exp, tag, {31'b0, cpu_irq}, {31'b0, exp});
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] s, input logic [31:0] c);
        evt_set = s; evt_clr = c;
        tick(1);
        evt_set = '0; evt_clr = '0;
    endtask

    task automatic wr_mask(input logic [31:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic wr_delay(input logic [15:0] d);
        dly_we = 1'b1; dly_wdata = d;
        tick(1);
        dly_we = 1'b0;
    endtask

    task automatic flush();
        pulse('0, 32'h7FFF_FFFF);
        tick(2);
    endtask

    task automatic t_reset();
        check(status === '0, "R11 status after reset", status, '0);
        chk_irq(1'b0, "R11 irq after reset");
        check(rsv_err === 1'b0, "R11 err after reset", {31'b0, rsv_err}, '0);
        // RESET_DELAY default 0: coalescable event must fire with no extra wait
        wr_mask(32'hFFFF_FFFF);
        pulse(B_RXDONE, '0);
        tick(1);
        chk_irq(1'b1, "R11 reset delay zero");
        wr_mask('0);
        flush();
    endtask

    task automatic t_set_clear();
        pulse(B_RXDONE | B_SWINT | 32'h20 | 32'h8000_0000, '0);
        check(status === (B_RXDONE | B_SWINT), "R1 R3 filtered set", status,
              B_RXDONE | B_SWINT);
        check(rsv_err === 1'b1, "R4 err on reserved set", {31'b0, rsv_err}, 1);
        tick(1);
        check(rsv_err === 1'b0, "R4 err one cycle only", {31'b0, rsv_err}, 0);
        pulse('0, B_SWINT | 32'h8000_0010);
        check(status === B_RXDONE, "R2 clear", status, B_RXDONE);
        check(rsv_err === 1'b1, "R4 err on reserved clear", {31'b0, rsv_err}, 1);
        pulse(B_RXDESC, B_RXDESC | B_RXDONE);
        check(status === B_RXDESC, "R2 set wins collision", status, B_RXDESC);
        pulse(32'hFFFF_FFFF, '0);
        check(status === 32'h0001_14C7, "R3 only implemented bits", status,
              32'h0001_14C7);
        tick(2);
        chk_irq(1'b0, "R5 masked off stays low");
        flush();
    endtask

    task automatic t_urgent();
        wr_mask(32'hFFFF_FFFF);
        wr_delay(16'd10);
        pulse(B_TXIDLE, '0);
        chk_irq(1'b0, "R6 not yet");
        tick(1);
        chk_irq(1'b1, "R6 urgent next cycle");
        pulse(B_RXDONE, '0);
        tick(3);
        chk_irq(1'b1, "R10 holds with new events");
        pulse('0, B_TXIDLE | B_RXDONE);
        chk_irq(1'b1, "R5 drop lags one cycle");
        tick(1);
        chk_irq(1'b0, "R5 drop after clear");
    endtask

    task automatic t_coalesce();
        wr_delay(16'd5);
        pulse(B_TXDONE, '0);
        tick(5);
        chk_irq(1'b0, "R7 still waiting");
        tick(1);
        chk_irq(1'b1, "R7 fires after delay");
        flush();
        wr_delay(16'd0);
        pulse(B_RXDESC, '0);
        tick(1);
        chk_irq(1'b1, "R7 zero delay immediate");
        flush();
    endtask

    task automatic t_urgent_cut();
        wr_delay(16'd20);
        pulse(B_TXDONE, '0);
        tick(3);
        chk_irq(1'b0, "R8 waiting");
        pulse(B_RXOVR, '0);
        tick(1);
        chk_irq(1'b1, "R8 urgent ends wait");
        flush();
    endtask

    task automatic t_cancel();
        wr_delay(16'd8);
        pulse(B_RXDONE, '0);
        tick(3);
        pulse('0, B_RXDONE);
        tick(10);
        chk_irq(1'b0, "R9 cancelled wait silent");
        pulse(B_RXDESC, '0);
        tick(8);
        chk_irq(1'b0, "R9 full new wait");
        tick(1);
        chk_irq(1'b1, "R9 fires after full wait");
        flush();
    endtask

    task automatic t_mask();
        wr_mask('0);
        pulse(B_SWINT, '0);
        tick(2);
        chk_irq(1'b0, "R5 masked pending low");
        wr_mask(B_SWINT);
        tick(1);
        chk_irq(1'b1, "R6 mask write raises");
        wr_mask('0);
        tick(1);
        chk_irq(1'b0, "R5 mask write drops");
        flush();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_urgent();
        t_coalesce();
        t_urgent_cut();
        t_cancel();
        t_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule